// File: doc/BRIEF.md
# Tick-Indexed Axon Spike Scheduler

This block sits between a local packet router and a grid of neurons that all compute in parallel. Each incoming payload is 12 bits wide and names one destination axon and one delivery tick. The scheduler records the spike as a single bit in a per-tick axon bitmap. It does not deliver the spike straight away.

The bitmaps form a ring of 16 slots, each 256 bits wide. The tick field of a payload is used directly as the slot index. On every tick pulse, the slot under the ring pointer does three things in the same clock edge:
- it is copied to the axon activity output, which feeds the neuron grid;
- it is cleared;
- the pointer moves on by one.

A spike therefore waits in its slot until the pointer reaches it. It is delivered exactly once.

The input uses a valid/ready handshake. A build-time mode sets what happens to a payload offered during a tick pulse. In the default mode the input stalls for that single cycle. In the pass-through mode the payload is accepted, and a write that lands on the slot being read is applied after the clear, so it is kept for that slot's next turn.

Top module: `axon_tick_scheduler`

## Requirements
- R1: After reset, `axon_vec` is all zeros, `axon_vec_valid` is low, `slot_ptr` is 0, every slot is empty, and `in_ready` is high whenever `tick` is low.
- R2: A payload is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_payload[11:4]` is the axon index and `in_payload[3:0]` is the slot index. Acceptance sets bit `axon` of slot `slot` and changes no other bit.
- R3: In the cycle after a clock edge with `tick` high, `axon_vec` equals the contents of slot `slot_ptr` as they stood before that edge, and `axon_vec_valid` is high for exactly that one cycle. Without a tick, `axon_vec` holds its value.
- R4: A slot that has been read is empty afterwards. If nothing is written to it, its next read, 16 ticks later, gives all zeros.
- R5: Each tick advances `slot_ptr` by one, wrapping from 15 to 0. Without a tick, `slot_ptr` holds its value.
- R6: Several accepted payloads with the same axon and slot produce one set bit, which is delivered once.
- R7: In the default mode (`WR_MODE = SCH_STALL_ON_TICK`), `in_ready` is low in any cycle where `tick` is high. A payload offered in that cycle has no effect on any slot.
- R8: In the pass-through mode (`WR_MODE = SCH_PASS_ON_TICK`), `in_ready` stays high during a tick. A write to the slot being read in that cycle is left out of the current `axon_vec` and appears on that slot's next read.
- R9: Spikes to different axons of one slot accumulate. A spike written to the slot under `slot_ptr` with no tick pending is delivered on the very next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Scheduler can accept a payload this cycle |
| in_payload | input | 12 | Axon index in bits 11:4, tick slot in bits 3:0 |
| tick | input | 1 | One-cycle tick boundary pulse |
| axon_vec | output | 256 | Axon activity for the tick just read |
| axon_vec_valid | output | 1 | High for one cycle when `axon_vec` is new |
| slot_ptr | output | 4 | Slot that the next tick will read |

## Verification
The bench fills every slot with spikes computed arithmetically, including duplicates. It then drives the pointer around the ring twice. This exposes a read taken from the wrong slot, a pointer that does not wrap, and a clear that is missing, which would replay stale spikes on the second lap. One slot is loaded with all 256 axons to catch a faulty or aliased axon decode. A write is also presented in the same cycle as the tick, aimed at the slot being read. Two instances run side by side, one in each mode. A stall-mode design that leaked this write, or a pass-through design that ordered the write before the clear, would either deliver the spike too early or lose it, and this shows up on the following lap.

// File: rtl/spksch_pkg.sv
package spksch_pkg;

   // Handling of a payload offered in the same cycle as a tick pulse
   typedef enum logic {
      SCH_STALL_ON_TICK = 1'b0,
      SCH_PASS_ON_TICK  = 1'b1
   } sch_wr_mode_e;

   function automatic int unsigned sch_pow2(input int unsigned w);
      return 32'd1 << w;
   endfunction

endpackage

// File: rtl/spksch_decode.sv
module spksch_decode #(
   parameter int unsigned AXON_W = 8,
   parameter int unsigned TICK_W = 4
) (
   input  logic [AXON_W+TICK_W-1:0]                      payload,
   output logic [TICK_W-1:0]                             slot_idx,
   output logic [spksch_pkg::sch_pow2(AXON_W)-1:0]       axon_bits
);
   localparam int unsigned NUM_AXONS = spksch_pkg::sch_pow2(AXON_W);

   logic [AXON_W-1:0] axon_idx;

   assign axon_idx = payload[AXON_W+TICK_W-1:TICK_W];
   assign slot_idx = payload[TICK_W-1:0];

   for (genvar a = 0; a < NUM_AXONS; a++) begin : g_axon
      assign axon_bits[a] = (axon_idx == AXON_W'(a));
   end

endmodule

// File: rtl/spksch_ptr.sv
module spksch_ptr #(
   parameter int unsigned TICK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [TICK_W-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else if (advance) ptr <= ptr + 1'b1;
   end

   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> ptr == TICK_W'($past(ptr) + 1'b1));

   // R5
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr));

endmodule

// File: rtl/spksch_ring.sv
module spksch_ring #(
   parameter int unsigned AXON_W = 8,
   parameter int unsigned TICK_W = 4
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       rd_en,
   input  logic [TICK_W-1:0]                          rd_slot,
   input  logic                                       wr_en,
   input  logic [TICK_W-1:0]                          wr_slot,
   input  logic [spksch_pkg::sch_pow2(AXON_W)-1:0]    wr_bits,
   output logic [spksch_pkg::sch_pow2(AXON_W)-1:0]    vec_q,
   output logic                                       vec_valid
);
   localparam int unsigned NUM_AXONS = spksch_pkg::sch_pow2(AXON_W);
   localparam int unsigned NUM_SLOTS = spksch_pkg::sch_pow2(TICK_W);

   logic [NUM_AXONS-1:0] slot_q [NUM_SLOTS];
   logic [NUM_AXONS-1:0] rd_data;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic clr_g;
      logic set_g;
      assign clr_g = rd_en && (rd_slot == TICK_W'(g));
      assign set_g = wr_en && (wr_slot == TICK_W'(g));
      // clear first, then merge a same-cycle write
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) slot_q[g] <= '0;
         else if (clr_g || set_g)
            slot_q[g] <= (clr_g ? '0 : slot_q[g]) | (set_g ? wr_bits : '0);
      end
   end

   assign rd_data = slot_q[rd_slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q     <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= rd_en;
         if (rd_en) vec_q <= rd_data;
      end
   end

   // R3
   vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> vec_valid);

   // R3
   vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !vec_valid);

   // R3
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(vec_q));

endmodule

// File: rtl/axon_tick_scheduler.sv
module axon_tick_scheduler
   import spksch_pkg::*;
#(
   parameter int unsigned  AXON_W  = 8,
   parameter int unsigned  TICK_W  = 4,
   parameter sch_wr_mode_e WR_MODE = SCH_STALL_ON_TICK
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [AXON_W+TICK_W-1:0]     in_payload,
   input  logic                         tick,
   output logic [(1<<AXON_W)-1:0]       axon_vec,
   output logic                         axon_vec_valid,
   output logic [TICK_W-1:0]            slot_ptr
);
   localparam int unsigned NUM_AXONS = sch_pow2(AXON_W);

   if (AXON_W < 1 || AXON_W > 10) begin : g_bad_axon_w
      $error("AXON_W out of supported range");
   end
   if (TICK_W < 1 || TICK_W > 6) begin : g_bad_tick_w
      $error("TICK_W out of supported range");
   end

   logic [TICK_W-1:0]    wr_slot;
   logic [NUM_AXONS-1:0] wr_bits;
   logic                 wr_en;

   if (WR_MODE == SCH_PASS_ON_TICK) begin : g_pass
      assign in_ready = 1'b1;
   end else begin : g_stall
      assign in_ready = !tick;
   end

   assign wr_en = in_valid && in_ready;

   spksch_decode #(.AXON_W(AXON_W), .TICK_W(TICK_W)) u_decode (
      .payload   (in_payload),
      .slot_idx  (wr_slot),
      .axon_bits (wr_bits)
   );

   spksch_ptr #(.TICK_W(TICK_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (tick),
      .ptr     (slot_ptr)
   );

   spksch_ring #(.AXON_W(AXON_W), .TICK_W(TICK_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (tick),
      .rd_slot   (slot_ptr),
      .wr_en     (wr_en),
      .wr_slot   (wr_slot),
      .wr_bits   (wr_bits),
      .vec_q     (axon_vec),
      .vec_valid (axon_vec_valid)
   );

endmodule

// File: tb/axon_tick_scheduler_test.sv
module axon_tick_scheduler_test;
   import spksch_pkg::*;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [11:0]  in_payload = '0;
   logic         tick = 1'b0;
   logic         rdy_s, rdy_p;
   logic [255:0] vec_s, vec_p;
   logic         vv_s, vv_p;
   logic [3:0]   ptr_s, ptr_p;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   logic [255:0] m_s [16];
   logic [255:0] m_p [16];
   int           eptr = 0;

   always #4 clk = ~clk;

   axon_tick_scheduler #(.WR_MODE(SCH_STALL_ON_TICK)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_s),
      .in_payload(in_payload), .tick(tick), .axon_vec(vec_s),
      .axon_vec_valid(vv_s), .slot_ptr(ptr_s));

   axon_tick_scheduler #(.WR_MODE(SCH_PASS_ON_TICK)) uut_pass (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_p),
      .in_payload(in_payload), .tick(tick), .axon_vec(vec_p),
      .axon_vec_valid(vv_p), .slot_ptr(ptr_p));

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // offer one payload with no tick; both variants accept it
   task automatic send(input int ax, input int sl);
      in_valid = 1'b1;
      in_payload = {8'(ax), 4'(sl)};
      #1;
      chk(rdy_s && rdy_p, "R2 in_ready high without tick", 256'({rdy_s, rdy_p}), 256'd3);
      @(negedge clk);
      in_valid = 1'b0;
      m_s[sl][ax] = 1'b1;
      m_p[sl][ax] = 1'b1;
   endtask

   // one tick pulse, optionally with a concurrent payload
   task automatic do_tick(input bit with_wr, input int ax, input int sl);
      logic [255:0] exp_s, exp_p;
      logic [255:0] hold_s;
      tick = 1'b1;
      in_valid = with_wr;
      in_payload = {8'(ax), 4'(sl)};
      #1;
      chk(!rdy_s, "R7 in_ready low during tick", 256'(rdy_s), 256'd0);
      chk(rdy_p, "R8 in_ready high during tick", 256'(rdy_p), 256'd1);
      @(negedge clk);
      tick = 1'b0;
      in_valid = 1'b0;
      exp_s = m_s[eptr];
      exp_p = m_p[eptr];
      m_s[eptr] = '0;
      m_p[eptr] = '0;
      if (with_wr) m_p[sl][ax] = 1'b1;   // applied after the clear
      eptr = (eptr + 1) % 16;
      chk(vec_s == exp_s, "R3/R4 axon_vec stall variant", vec_s, exp_s);
      chk(vec_p == exp_p, "R3/R8 axon_vec pass variant", vec_p, exp_p);
      chk(vv_s && vv_p, "R3 axon_vec_valid pulse", 256'({vv_s, vv_p}), 256'd3);
      chk(ptr_s == 4'(eptr) && ptr_p == 4'(eptr), "R5 slot_ptr advance/wrap",
          256'({ptr_s, ptr_p}), 256'({4'(eptr), 4'(eptr)}));
      hold_s = vec_s;
      @(negedge clk);
      chk(!vv_s && !vv_p, "R3 valid one cycle only", 256'({vv_s, vv_p}), 256'd0);
      chk(vec_s == hold_s && ptr_s == 4'(eptr), "R3/R5 hold without tick",
          vec_s, hold_s);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_s[i] = '0;
         m_p[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(vec_s == '0 && vec_p == '0, "R1 reset axon_vec", vec_s, '0);
      chk(!vv_s && !vv_p && ptr_s == 0 && ptr_p == 0, "R1 reset valid/ptr",
          256'({vv_s, vv_p, ptr_s, ptr_p}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rdy_s && rdy_p, "R1 ready after reset", 256'({rdy_s, rdy_p}), 256'd3);

      // R2 R6 R9: fill every slot, with a duplicate per slot
      for (int s = 0; s < 16; s++) begin
         for (int k = 0; k < 4; k++) send((s * 37 + k * 53 + 1) % 256, s);
         send((s * 37 + 1) % 256, s);
      end
      // R3 R5: one full lap, wrapping 15 -> 0
      for (int t = 0; t < 16; t++) do_tick(1'b0, 0, 0);
      // R4: second lap must be empty
      for (int t = 0; t < 16; t++) do_tick(1'b0, 0, 0);

      // R2 exhaustive axon decode into slot 5
      for (int a = 0; a < 256; a++) send(a, 5);
      // R9: spike into the current slot (0) goes out on the next tick
      send(200, 0);
      send(201, 0);
      for (int t = 0; t < 16; t++) do_tick(1'b0, 0, 0);

      // R7 R8: tick-cycle writes aimed at the slot being read, and elsewhere
      for (int t = 0; t < 16; t++) do_tick(1'b1, (t * 29 + 7) % 256, (t % 2 == 0) ? t : (t + 3) % 16);
      // next lap shows which tick-cycle writes were kept
      for (int t = 0; t < 16; t++) do_tick(1'b0, 0, 0);
      // R6: duplicate in a slot just passed waits one full lap
      send(9, (eptr + 15) % 16);
      send(9, (eptr + 15) % 16);
      for (int t = 0; t < 16; t++) do_tick(1'b0, 0, 0);

      finish_run();
   end

endmodule